// File: doc/BRIEF.md
# Paged Digital I/O Controller with Edge Interrupts

This block gives a host a byte-wide register window of sixteen addresses onto forty-eight general-purpose lines, organised as six 8-bit ports. Each port has an output latch that the host writes and an input path that the host reads. Every pin passes through a two-flop synchronizer before it reaches the read path or the edge logic. A combined control register at offset 0x07 does two things. It picks which bank of per-port registers appears at offsets 0x08 to 0x0A, and it can freeze any port's output latch against host writes.

The first three ports can raise interrupts. Each of their bits has a polarity setting that picks a rising or falling edge, and an enable. An edge that is both detected and enabled is captured in a sticky identification register. A summary of which identification registers hold events is readable at offset 0x06 and is also driven onto a single interrupt line. Software clears events by writing zero to an identification register. The host interface is a plain single-cycle strobe bus: a write commits on the clock edge where the write strobe is high, and the read data is a combinational function of the address. There is no handshake and no back-pressure.

Top module: `pdio_ctrl`

## Requirements
- R1: After reset, every output latch is 0, the interrupt line is low, the pending register reads 0, page 0 is selected and no port is locked.
- R2: A write to offset k (0 to 5) of an unlocked port loads that port's latch, which drives pin_out bits 8k+7 down to 8k on the next cycle.
- R3: A read of offset k (0 to 5) returns the port's pins after a two-flop synchronizer. A pin change made before a clock edge appears on the read two rising edges later.
- R4: Offset 0x07 is write-only and reads 0. Bits 7:6 of the written value select the page and hold until rewritten. Bit k of bits 5:0 locks port k, and a write to a locked port leaves its latch unchanged.
- R5: Offset 0x08+i (i = 0, 1, 2) addresses port i's polarity register when the page is 1, its enable register when the page is 2, and its identification register when the page is 3. With page 0 selected these offsets ignore writes. Reads there return 0 on every page except 3.
- R6: When a synchronized input bit of port 0, 1 or 2 changes, its identification bit is set if its enable bit is 1 and the change matches its polarity bit (1 selects a rising edge, 0 a falling edge). The bit is set three rising edges after the pin changes. Disabled bits never set.
- R7: An identification bit stays set until a write of 0x00 reaches that identification register on page 3, which clears the whole register. A nonzero write there has no effect.
- R8: If a clearing write and a newly detected enabled edge meet in the same cycle, the register keeps the new edge's bit and clears the rest.
- R9: Bit i of offset 0x06 is 1 exactly when identification register i is nonzero, and bits 7:3 read 0. The interrupt line is the OR of those three bits.
- R10: Offsets 0x0B to 0x0F read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, commits on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 48 | Input pins, port k on bits 8k+7:8k |
| pin_out | output | 48 | Output latches, port k on bits 8k+7:8k |
| irq | output | 1 | Interrupt request, high while any event is pending |

## Verification
The bench builds the block with its default parameters: six ports of eight bits, three of them able to raise interrupts. With these values every offset of the sixteen-address window is decoded, so the unused tail 0x0B to 0x0F, every lock bit and all three paged registers of each page can be reached. Random writes over the whole window, including random lock masks, page changes and zero-valued clears, are interleaved with random pin changes. These exercise polarity and enable mixes across all interrupt-capable bits. A directed case lines up a clearing write with the capture cycle of a new edge.

// File: rtl/pdio_pkg.sv
package pdio_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_ENA  = 2'd2,
    PG_IDR  = 2'd3
  } page_e;

  localparam int unsigned BUS_AW = 4;
  localparam int unsigned BUS_DW = 8;
  localparam logic [BUS_AW-1:0] OFS_PEND  = 4'h6;
  localparam logic [BUS_AW-1:0] OFS_PGLK  = 4'h7;
  localparam logic [BUS_AW-1:0] OFS_PAGED = 4'h8;
endpackage

// File: rtl/pdio_sync.sv
module pdio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_in;
      sync_q <= meta_q;
    end
  end

  assign d_out = sync_q;
endmodule

// File: rtl/pdio_edge_port.sv
module pdio_edge_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_in,
  input  logic         pol_we,
  input  logic         en_we,
  input  logic         id_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] id_q,
  output logic         pend
);
  logic [W-1:0] pol_q, en_q, prev_q, id_r;
  logic [W-1:0] rise, fall, edge_v, hit;
  logic         clr;

  always_comb begin
    rise   = sync_in & ~prev_q;
    fall   = ~sync_in & prev_q;
    edge_v = (pol_q & rise) | (~pol_q & fall);
    hit    = edge_v & en_q;
    clr    = id_we && (wdata == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q  <= '0;
      en_q   <= '0;
      prev_q <= '0;
      id_r   <= '0;
    end else begin
      prev_q <= sync_in;
      if (pol_we) pol_q <= wdata;
      if (en_we)  en_q  <= wdata;
      id_r <= (clr ? '0 : id_r) | hit;
    end
  end

  assign id_q = id_r;
  assign pend = |id_r;

  // R7: without a clearing write, no captured bit is lost
  p_id_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (($past(id_r) & ~id_r) == '0));

  // R8: a clear meeting a new edge keeps exactly the new edge's bits
  p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (hit != '0)) |=> (id_r == $past(hit)));

  // R6: a disabled bit never becomes newly set
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((id_r & ~$past(id_r) & ~$past(en_q)) == '0));
endmodule

// File: rtl/pdio_ctrl.sv
module pdio_ctrl #(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned NUM_IRQ   = 3,
  parameter int unsigned PORT_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [3:0]                    bus_addr,
  input  logic                          bus_wr,
  input  logic [7:0]                    bus_wdata,
  output logic [7:0]                    bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_out,
  output logic                          irq
);
  import pdio_pkg::*;

  localparam int unsigned PINS = NUM_PORTS * PORT_W;

  page_e                  page_q;
  logic [NUM_PORTS-1:0]   lock_q;
  logic [PORT_W-1:0]      pout_q [NUM_PORTS];
  logic [PINS-1:0]        pin_sync;
  logic [PORT_W-1:0]      id_v   [NUM_IRQ];
  logic [NUM_IRQ-1:0]     pend_v;
  logic [NUM_IRQ-1:0]     paged_wr;

  pdio_sync #(.W(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_in),
    .d_out (pin_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= PG_NONE;
      lock_q <= '0;
    end else if (bus_wr && bus_addr == OFS_PGLK) begin
      page_q <= page_e'(bus_wdata[7:6]);
      lock_q <= bus_wdata[NUM_PORTS-1:0];
    end
  end

  generate
    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
      logic wr_k;
      assign wr_k = bus_wr && (bus_addr == BUS_AW'(k)) && !lock_q[k];

      always_ff @(posedge clk) begin
        if (!rst_n)    pout_q[k] <= '0;
        else if (wr_k) pout_q[k] <= bus_wdata[PORT_W-1:0];
      end

      assign pin_out[k*PORT_W +: PORT_W] = pout_q[k];

      // R4: a locked port keeps its latch through a write
      p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == BUS_AW'(k) && lock_q[k]) |=> $stable(pout_q[k]));
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      assign paged_wr[i] = bus_wr && (bus_addr == OFS_PAGED + BUS_AW'(i));

      pdio_edge_port #(.W(PORT_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (pin_sync[i*PORT_W +: PORT_W]),
        .pol_we  (paged_wr[i] && page_q == PG_POL),
        .en_we   (paged_wr[i] && page_q == PG_ENA),
        .id_we   (paged_wr[i] && page_q == PG_IDR),
        .wdata   (bus_wdata[PORT_W-1:0]),
        .id_q    (id_v[i]),
        .pend    (pend_v[i])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (bus_addr == BUS_AW'(k)) bus_rdata = pin_sync[k*PORT_W +: PORT_W];
    end
    if (bus_addr == OFS_PEND) bus_rdata = BUS_DW'(pend_v);
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (bus_addr == OFS_PAGED + BUS_AW'(i) && page_q == PG_IDR) bus_rdata = id_v[i];
    end
  end

  assign irq = |pend_v;

  // R10: unused tail of the window reads zero
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > OFS_PAGED + BUS_AW'(NUM_IRQ - 1)) |-> (bus_rdata == '0));

  // R4: the page/lock register is write-only
  p_pglk_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_PGLK) |-> (bus_rdata == '0));

  // R9: interrupt line follows the pending register contents
  p_irq_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_PEND) |-> (irq == (bus_rdata != '0)));
endmodule

// File: tb/test_pdio_ctrl.sv
`timescale 1ns/1ps
module test_pdio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_out;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]  m_out [6];
  logic [7:0]  m_pol [3];
  logic [7:0]  m_en  [3];
  logic [7:0]  m_id  [3];
  logic [1:0]  m_page;
  logic [5:0]  m_lock;
  logic [47:0] m_pin;

  always #2.5 clk = ~clk;

  pdio_ctrl i_pdio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pend();
    logic [7:0] p = '0;
    for (int i = 0; i < 3; i++) p[i] = (m_id[i] != 0);
    return p;
  endfunction

  function automatic logic [7:0] events(input logic [7:0] o, input logic [7:0] n,
                                        input logic [7:0] pol, input logic [7:0] en);
    return ((pol & ~o & n) | (~pol & o & ~n)) & en;
  endfunction

  task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
    if (a < 6) begin
      if (!m_lock[a]) m_out[a] = d;
    end else if (a == 7) begin
      m_page = d[7:6];
      m_lock = d[5:0];
    end else if (a >= 8 && a <= 10) begin
      case (m_page)
        2'd1: m_pol[a-8] = d;
        2'd2: m_en[a-8] = d;
        2'd3: if (d == 0) m_id[a-8] = '0;
        default: ;
      endcase
    end
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic bread(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(input logic [47:0] nv);
    @(negedge clk);
    for (int i = 0; i < 3; i++)
      m_id[i] |= events(m_pin[i*8 +: 8], nv[i*8 +: 8], m_pol[i], m_en[i]);
    m_pin = nv;
    pin_in = nv;
    repeat (4) @(negedge clk);
  endtask

  task automatic audit(input string tag);
    logic [7:0] r;
    for (int k = 0; k < 6; k++) chk({tag, " R2 latch"}, pin_out[k*8 +: 8], m_out[k]);
    for (int k = 0; k < 6; k++) begin
      bread(4'(k), r); chk({tag, " R3 port read"}, r, m_pin[k*8 +: 8]);
    end
    bread(4'h6, r); chk({tag, " R9 pending"}, r, exp_pend());
    chk({tag, " R9 irq"}, {7'd0, irq}, {7'd0, exp_pend() != 0});
    bread(4'h7, r); chk({tag, " R4 pglk read"}, r, 8'h00);
    for (int i = 0; i < 3; i++) begin
      bread(4'(8 + i), r);
      chk({tag, " R5 paged read"}, r, (m_page == 2'd3) ? m_id[i] : 8'h00);
    end
    for (int a = 11; a < 16; a++) begin
      bread(4'(a), r); chk({tag, " R10 unused read"}, r, 8'h00);
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 6; k++) m_out[k] = '0;
    for (int i = 0; i < 3; i++) begin m_pol[i] = '0; m_en[i] = '0; m_id[i] = '0; end
    m_page = '0; m_lock = '0; m_pin = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_out low", pin_out[7:0] | pin_out[47:40], 8'h00);
    chk("R1 irq low", {7'd0, irq}, 8'h00);
    audit("R1");

    // R2 latches
    for (int k = 0; k < 6; k++) bwrite(4'(k), 8'(8'h11 * (k + 1)));
    audit("R2");

    // R3 synchronizer latency
    @(negedge clk);
    pin_in[47:40] = 8'hA5;
    @(negedge clk);
    bus_addr = 4'h5; #1 chk("R3 one edge old", bus_rdata, 8'h00);
    @(negedge clk);
    #1 chk("R3 two edges new", bus_rdata, 8'hA5);
    m_pin[47:40] = 8'hA5;

    // R4 lock
    bwrite(4'h7, 8'b00_000101);
    bwrite(4'h0, 8'hAA);
    bwrite(4'h1, 8'h55);
    bwrite(4'h2, 8'hCC);
    chk("R4 locked port 0", pin_out[7:0], 8'h11);
    chk("R4 unlocked port 1", pin_out[15:8], 8'h55);
    chk("R4 locked port 2", pin_out[23:16], 8'h33);
    audit("R4");
    bwrite(4'h7, 8'h00);

    // R5 page 0 ignores, R6 rising detection
    bwrite(4'h7, 8'h40); bwrite(4'h8, 8'hFF);
    bwrite(4'h7, 8'h00); bwrite(4'h8, 8'hFF);
    set_pins(m_pin | 48'h0000_0000_00FF);
    bwrite(4'h7, 8'hC0);
    bread(4'h8, r); chk("R5 page0 enable ignored", r, 8'h00);
    bwrite(4'h7, 8'h80); bwrite(4'h8, 8'h3C);
    set_pins(m_pin & ~48'h0000_0000_00FF);
    set_pins(m_pin | 48'h0000_0000_00FF);
    bwrite(4'h7, 8'hC0);
    bread(4'h8, r); chk("R6 rising enabled bits", r, 8'h3C);
    chk("R9 irq on event", {7'd0, irq}, 8'h01);

    // R6 falling on port 1
    bwrite(4'h7, 8'h40); bwrite(4'h9, 8'h00);
    bwrite(4'h7, 8'h80); bwrite(4'h9, 8'h0F);
    set_pins(m_pin | 48'h0000_0000_FF00);
    set_pins(m_pin & ~48'h0000_0000_FF00);
    bwrite(4'h7, 8'hC0);
    bread(4'h9, r); chk("R6 falling enabled bits", r, 8'h0F);
    bread(4'h6, r); chk("R9 pending two", r, 8'h03);

    // R7 nonzero write ignored, zero clears
    bwrite(4'h8, 8'hFF);
    bread(4'h8, r); chk("R7 nonzero ignored", r, 8'h3C);
    bwrite(4'h8, 8'h00);
    bread(4'h8, r); chk("R7 zero clears", r, 8'h00);
    bwrite(4'h9, 8'h00);
    chk("R9 irq drops", {7'd0, irq}, 8'h00);

    // R8 clear meets new edge on port 2
    bwrite(4'h7, 8'h40); bwrite(4'hA, 8'hFF);
    bwrite(4'h7, 8'h80); bwrite(4'hA, 8'hFF);
    bwrite(4'h7, 8'hC0);
    set_pins(m_pin | 48'h0000_0080_0000);
    bread(4'hA, r); chk("R8 setup", r, 8'h80);
    @(negedge clk);
    pin_in[16] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 4'hA; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    m_pin[16] = 1'b1; m_id[2] = 8'h01;
    repeat (3) @(negedge clk);
    bread(4'hA, r); chk("R8 new edge wins", r, 8'h01);

    // R10 unused writes
    for (int a = 11; a < 16; a++) bwrite(4'(a), 8'hFF);
    audit("R10");

    // random phase
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 3) == 0) begin
        logic [47:0] np = m_pin;
        np[23:0] = np[23:0] ^ 24'($urandom & $urandom);
        if (($urandom % 4) == 0) np[47:24] = 24'($urandom);
        set_pins(np);
      end else begin
        logic [3:0] a = 4'($urandom);
        logic [7:0] d = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
        bwrite(a, d);
      end
      if ((it % 25) == 24) audit("RND");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule